// File: doc/BRIEF.md
# System Call Trap State Update

This block computes, in one combinational step, the architectural state that a 64-bit core must save and install when it takes a system-call trap. It receives the address of the trapping instruction, the 32-bit instruction word, the current machine state register (MSR) and an operation select. When the select names the system-call operation, it produces three results, each with a valid flag. The first is the return address to save. The second is a filtered copy of the old MSR. The third is the MSR value that is in force once the trap has been taken.

Bit ranges in the instruction and in the MSR are written here in LSB-0 numbering, where bit 0 is the least significant bit. In the new MSR, address translation, external interrupt enable, the floating-point exception mode bits and the recoverable-interrupt bit are cleared. The hypervisor-state bit is set only when the instruction's 7-bit level field holds the value 1. Every other MSR bit passes through unchanged. For any other operation select the block stays quiet: all flags are low and all data outputs are zero. The surrounding pipeline decides when to register and commit the outputs.

Top module: `sc_trap_unit`

## Requirements
- R1: When `op_sel` equals 2'd1 (system call), `srr0_valid`, `srr1_valid` and `msr_valid` are all 1.
- R2: For a system call, `srr0_data` equals `cur_addr + 4` modulo 2^64, so an address of 2^64-4 or above wraps around.
- R3: For a system call, `srr1_data` bits [30:27] and [21:16] are 0.
- R4: For a system call, every `srr1_data` bit outside [30:27] and [21:16] equals the same bit of `msr_in`.
- R5: For a system call, `msr_data` bits 1, 4, 5, 8, 11 and 15 are 0. These are the recoverable, data-translate, instruction-translate, exception-mode-1, exception-mode-0 and external-interrupt bits.
- R6: For a system call, `msr_data` bit 60 is 1 exactly when the level field `insn[11:5]` equals 7'd1, and 0 for every other level value.
- R7: For a system call, every `msr_data` bit other than 1, 4, 5, 8, 11, 15 and 60 equals the same bit of `msr_in`.
- R8: When `op_sel` is not 2'd1, all three valid flags are 0 and `srr0_data`, `srr1_data` and `msr_data` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation select; 2'd1 selects system call |
| cur_addr | input | 64 | Address of the current instruction |
| insn | input | 32 | Instruction word; level field in bits [11:5] |
| msr_in | input | 64 | Machine state before the trap |
| srr0_valid | output | 1 | Return address result is valid |
| srr0_data | output | 64 | Saved return address |
| srr1_valid | output | 1 | Saved state result is valid |
| srr1_data | output | 64 | Filtered copy of the old machine state |
| msr_valid | output | 1 | New machine state is valid |
| msr_data | output | 64 | Machine state after the trap |

## Verification
The level field is swept through all 128 values, with a fresh random MSR for each value. This shows that only the value 1 raises the hypervisor bit, and that the cleared bits and the pass-through bits stay correct whatever the rest of the state holds. All-ones and all-zero MSR patterns separate forced-zero bits from copied bits in both saved and new state: a copy error shows up on the ones, a stuck bit on the zeros. Addresses just below, at and above the 2^64-4 boundary show whether the return address wraps. Every select value is applied with busy inputs to confirm that the outputs are quiet outside a system call.

// File: rtl/sc_trap_pkg.sv
// Shared constants and helpers for the system-call trap unit.
// Assumes a 64-bit machine state word and 32-bit instruction words.
package sc_trap_pkg;

    localparam int XLEN    = 64;
    localparam int ILEN    = 32;
    localparam int OP_W    = 2;
    localparam int INSN_STEP = 4;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE    = 2'd0,
        OP_SYSCALL = 2'd1,
        OP_RETURN  = 2'd2,
        OP_MISC    = 2'd3
    } trap_op_e;

    // LSB-0 positions of machine state bits touched by the trap
    localparam int BIT_HV  = 60;
    localparam int BIT_EE  = 15;
    localparam int BIT_FE0 = 11;
    localparam int BIT_FE1 = 8;
    localparam int BIT_IR  = 5;
    localparam int BIT_DR  = 4;
    localparam int BIT_RI  = 1;

    // Level field inside the instruction word (LSB-0)
    localparam int LEV_LSB = 5;
    localparam int LEV_W   = 7;
    localparam logic [LEV_W-1:0] LEV_HYP = 7'd1;

    // Mask covering big-endian-numbered bits s..e of a W-bit word
    function automatic logic [XLEN-1:0] be_span(input int w, input int s, input int e);
        logic [XLEN-1:0] m;
        m = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (i >= (w-1-e) && i <= (w-1-s)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sc_srr0_calc.sv
// Return-address generator: adds the instruction step to the current
// address with natural modulo-2^W wraparound. Output is zero when idle.
module sc_srr0_calc #(
    parameter int W    = sc_trap_pkg::XLEN,
    parameter int STEP = sc_trap_pkg::INSN_STEP
) (
    input  logic         en,
    input  logic [W-1:0] addr,
    output logic         valid,
    output logic [W-1:0] data
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    // Select the incremented address or zero
    always_comb begin
        valid = en;
        data  = en ? (addr + STEP_V) : '0;
    end
endmodule

// File: rtl/sc_srr1_filter.sv
// Saved-state filter: copies the old machine state with two reserved
// ranges (big-endian 33..36 and 42..47) forced to zero. Zero when idle.
module sc_srr1_filter #(
    parameter int W = sc_trap_pkg::XLEN
) (
    input  logic         en,
    input  logic [W-1:0] state_in,
    output logic         valid,
    output logic [W-1:0] data
);
    import sc_trap_pkg::*;

    localparam logic [XLEN-1:0] DROP_MASK = be_span(W, 33, 36) | be_span(W, 42, 47);

    logic [W-1:0] kept;

    // Per-bit keep or drop, chosen by the constant mask
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (DROP_MASK[b]) begin : g_drop
            assign kept[b] = 1'b0;
        end else begin : g_keep
            assign kept[b] = state_in[b];
        end
    end

    // Gate the filtered word by the enable
    always_comb begin
        valid = en;
        data  = en ? kept : '0;
    end
endmodule

// File: rtl/sc_msr_update.sv
// New machine state builder: clears translate, interrupt-enable,
// exception-mode and recoverable bits, sets hypervisor state from the
// level field. Assumes no alternate-interrupt-location control exists.
module sc_msr_update #(
    parameter int W  = sc_trap_pkg::XLEN,
    parameter int IW = sc_trap_pkg::ILEN
) (
    input  logic          en,
    input  logic [W-1:0]  state_in,
    input  logic [IW-1:0] insn,
    output logic          valid,
    output logic [W-1:0]  data
);
    import sc_trap_pkg::*;

    localparam logic [W-1:0] CLR_MASK = (W'(1) << BIT_IR)  | (W'(1) << BIT_DR)  |
                                        (W'(1) << BIT_FE0) | (W'(1) << BIT_FE1) |
                                        (W'(1) << BIT_EE)  | (W'(1) << BIT_RI)  |
                                        (W'(1) << BIT_HV);

    logic [LEV_W-1:0] level;
    logic             to_hyp;
    logic [W-1:0]     next_state;

    // Extract the level field and decide the hypervisor bit
    always_comb begin
        level  = insn[LEV_LSB +: LEV_W];
        to_hyp = (level == LEV_HYP);
    end

    // Clear the masked bits and insert the hypervisor decision
    always_comb begin
        next_state         = state_in & ~CLR_MASK;
        next_state[BIT_HV] = to_hyp;
    end

    // Gate the result by the enable
    always_comb begin
        valid = en;
        data  = en ? next_state : '0;
    end
endmodule

// File: rtl/sc_trap_unit.sv
// System-call trap state update, top level. Decodes the operation
// select and drives the three result paths. Purely combinational;
// the caller registers and commits the results.
module sc_trap_unit (
    input  logic [1:0]  op_sel,
    input  logic [63:0] cur_addr,
    input  logic [31:0] insn,
    input  logic [63:0] msr_in,
    output logic        srr0_valid,
    output logic [63:0] srr0_data,
    output logic        srr1_valid,
    output logic [63:0] srr1_data,
    output logic        msr_valid,
    output logic [63:0] msr_data
);
    import sc_trap_pkg::*;

    logic is_sc;

    // Decode the system-call operation
    always_comb begin
        is_sc = (trap_op_e'(op_sel) == OP_SYSCALL);
    end

    sc_srr0_calc #(.W(XLEN), .STEP(INSN_STEP)) u_srr0 (
        .en    (is_sc),
        .addr  (cur_addr),
        .valid (srr0_valid),
        .data  (srr0_data)
    );

    sc_srr1_filter #(.W(XLEN)) u_srr1 (
        .en       (is_sc),
        .state_in (msr_in),
        .valid    (srr1_valid),
        .data     (srr1_data)
    );

    sc_msr_update #(.W(XLEN), .IW(ILEN)) u_msr (
        .en       (is_sc),
        .state_in (msr_in),
        .insn     (insn),
        .valid    (msr_valid),
        .data     (msr_data)
    );
endmodule

// File: rtl/sc_trap_unit_chk.sv
// Property checker for sc_trap_unit, attached by bind. Uses immediate
// assertions evaluated whenever the combinational results change.
module sc_trap_unit_chk (
    input logic [1:0]  op_sel,
    input logic [63:0] cur_addr,
    input logic [31:0] insn,
    input logic [63:0] msr_in,
    input logic        srr0_valid,
    input logic [63:0] srr0_data,
    input logic        srr1_valid,
    input logic [63:0] srr1_data,
    input logic        msr_valid,
    input logic [63:0] msr_data
);
    localparam logic [63:0] SRR1_ZERO = 64'h0000_0000_783F_0000;
    localparam logic [63:0] MSR_CLR   = 64'h0000_0000_0000_8932;

    // Check every result path against the select and the inputs
    always_comb begin
        if (op_sel == 2'd1) begin
            AST_ALL_VALID: assert (srr0_valid && srr1_valid && msr_valid); // R1
            AST_RET_ADDR: assert (srr0_data - cur_addr == 64'd4); // R2
            AST_SRR1_RSVD_ZERO: assert ((srr1_data & SRR1_ZERO) == 64'd0); // R3
            AST_SRR1_COPY: assert (((srr1_data ^ msr_in) & ~SRR1_ZERO) == 64'd0); // R4
            AST_MSR_CLEARED: assert ((msr_data & MSR_CLR) == 64'd0); // R5
            AST_MSR_HV: assert (msr_data[60] == (insn[11:5] == 7'd1)); // R6
        end else begin
            AST_IDLE_QUIET: assert (!srr0_valid && !srr1_valid && !msr_valid &&
                                    srr0_data == 64'd0 && srr1_data == 64'd0 &&
                                    msr_data == 64'd0); // R8
        end
    end
endmodule

bind sc_trap_unit sc_trap_unit_chk u_chk (
    .op_sel     (op_sel),
    .cur_addr   (cur_addr),
    .insn       (insn),
    .msr_in     (msr_in),
    .srr0_valid (srr0_valid),
    .srr0_data  (srr0_data),
    .srr1_valid (srr1_valid),
    .srr1_data  (srr1_data),
    .msr_valid  (msr_valid),
    .msr_data   (msr_data)
);

// File: tb/tb_sc_trap_unit.sv
// Self-checking bench for sc_trap_unit: level-field sweep, MSR
// patterns, address wraparound and select sweep.
module tb_sc_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [63:0] cur_addr = '0;
    logic [31:0] insn = '0;
    logic [63:0] msr_in = '0;
    logic        srr0_valid, srr1_valid, msr_valid;
    logic [63:0] srr0_data, srr1_data, msr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [63:0] ZMASK = 64'h0000_0000_783F_0000;
    localparam logic [63:0] CMASK = 64'h0000_0000_0000_8932;

    always #4 clk = ~clk;

    sc_trap_unit dut (
        .op_sel(op_sel), .cur_addr(cur_addr), .insn(insn), .msr_in(msr_in),
        .srr0_valid(srr0_valid), .srr0_data(srr0_data),
        .srr1_valid(srr1_valid), .srr1_data(srr1_data),
        .msr_valid(msr_valid), .msr_data(msr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [63:0] a, input logic [31:0] iw, input logic [63:0] m);
        @(posedge clk);
        op_sel = op; cur_addr = a; insn = iw; msr_in = m;
        @(negedge clk);
    endtask

    // Full check of one system-call vector
    task automatic check_sc(input logic [63:0] a, input logic [31:0] iw, input logic [63:0] m);
        logic [63:0] e0, e1, em;
        apply(2'd1, a, iw, m);
        e0 = a + 64'd4;
        e1 = m & ~ZMASK;
        em = m & ~CMASK;
        em[60] = (iw[11:5] == 7'd1);
        chk(srr0_valid && srr1_valid && msr_valid, "R1",
            {61'd0, srr0_valid, srr1_valid, msr_valid}, 64'd7);
        chk(srr0_data == e0, "R2", srr0_data, e0);
        chk((srr1_data & ZMASK) == 0, "R3", srr1_data & ZMASK, 64'd0);
        chk((srr1_data & ~ZMASK) == (m & ~ZMASK), "R4", srr1_data, e1);
        chk((msr_data & CMASK) == 0, "R5", msr_data & CMASK, 64'd0);
        chk(msr_data[60] == em[60], "R6", {63'd0, msr_data[60]}, {63'd0, em[60]});
        chk(msr_data == em, "R7", msr_data, em);
    endtask

    task automatic check_idle(input logic [1:0] op);
        apply(op, {$urandom, $urandom}, $urandom, {$urandom, $urandom});
        chk(!srr0_valid && !srr1_valid && !msr_valid && srr0_data == 0 &&
            srr1_data == 0 && msr_data == 0, "R8",
            srr0_data | srr1_data | msr_data | {61'd0, srr0_valid, srr1_valid, msr_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: idle select gives quiet outputs (R8)
        chk(!srr0_valid && !srr1_valid && !msr_valid && srr0_data == 0, "R8",
            srr0_data, 64'd0);
        // Level-field sweep with random state (R6)
        for (int lv = 0; lv < 128; lv++) begin
            logic [31:0] w;
            w = $urandom;
            w[11:5] = 7'(lv);
            check_sc({$urandom, $urandom}, w, {$urandom, $urandom});
        end
        // Extreme state patterns, level 1 and level 0 (R3 R4 R5 R7)
        check_sc(64'h1000, 32'h4400_0022, '1);
        check_sc(64'h1000, 32'h4400_0002, '1);
        check_sc(64'h1000, 32'h4400_0022, '0);
        check_sc(64'h1000, 32'h4400_0002, '0);
        // Wraparound of the return address (R2)
        for (int k = 0; k < 8; k++) begin
            check_sc(64'hFFFF_FFFF_FFFF_FFF8 + 64'(k), $urandom, {$urandom, $urandom});
        end
        // Non-system-call selects stay quiet (R8)
        for (int r = 0; r < 16; r++) begin
            check_idle(2'd0);
            check_idle(2'd2);
            check_idle(2'd3);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(8 * 100000);
                n_chk++; n_bad++;
                $display("FAIL watchdog act=timeout exp=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule